// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block turns a fast input clock into the bit clock and the frame-sync pulse of a synchronous audio serial port. A packed configuration word sets three things: the divide ratio from the input clock to the bit clock, the frame length in bit periods, and how long the frame-sync stays active. Each of these fields holds its value minus one. A configuration bit decides whether the block drives frame sync at all. Two run inputs release the generator in stages. The first starts the bit clock. The second allows framing, and framing starts at the next bit-period boundary. This lets a serial port clock its shifters before any frame begins.

Behaviour is set by a three-state controller. `SRG_IDLE` holds both counters cleared and both outputs at their inactive level. `SRG_CLK_ONLY` runs the bit-clock divider with no framing. `SRG_FRAMING` also steps the frame counter once per bit period. The transitions are:
- `SRG_IDLE` to `SRG_CLK_ONLY`, when `gen_run` is high.
- `SRG_CLK_ONLY` to `SRG_FRAMING`, when `fs_run` is high at a bit boundary.
- `SRG_FRAMING` to `SRG_CLK_ONLY`, when `fs_run` drops.
- Any state to `SRG_IDLE`, when `gen_run` drops. This takes priority over every other transition.

There are two output lanes, transmit and receive. Each lane has its own bit-clock polarity bit and its own frame-sync polarity bit.

Top module: `audio_srg`

## Requirements
- R1: While reset is asserted and after it is released with `gen_run` low, each bit-clock output equals the inverse of its polarity bit, and each frame-sync output equals its polarity bit (inactive).
- R2: The divide field is `gen_cfg[7:0]`. Let D be that field, with a field value of 0 treated as 1. The bit period is D+1 input clocks. Within a period the divide count runs 0..D, and the internal bit clock is low for counts 0..floor(D/2) and high for the remaining counts.
- R3: Bit-clock polarity is set by `pol[1]` (transmit) and `pol[0]` (receive). When the bit is 1 the output follows the internal bit clock, which falls at each bit boundary. When the bit is 0 the output is inverted.
- R4: If `gen_run` is low at a clock edge, the block is in `SRG_IDLE` after that edge. In that state both counters are cleared and the outputs are at their R1 levels. At the first edge where `gen_run` is seen high, the block enters `SRG_CLK_ONLY` with the divide count at 0.
- R5: Framing starts only from `SRG_CLK_ONLY`, at an edge where `fs_run` is high and the divide count equals D. The frame count is 0 during the bit period that follows.
- R6: The frame period field is `gen_cfg[27:16]`. Let F be its value. A frame lasts F+1 bit periods, and the frame count then wraps to 0.
- R7: The frame width field is `gen_cfg[15:8]`. Let W be its value. When W < F, frame sync is active for frame counts 0..W.
- R8: When W >= F, frame sync is active for every frame count except F, the last bit period.
- R9: Frame-sync polarity is set by `pol[3]` (transmit) and `pol[2]` (receive). A value of 1 makes the output active low, and 0 makes it active high.
- R10: When `gen_cfg[28]` is 0, both frame-sync outputs stay inactive while framing. The bit clock is not affected.
- R11: If `fs_run` is low at an edge during `SRG_FRAMING`, the block returns to `SRG_CLK_ONLY`. Frame sync is then inactive and the bit clock continues without a break in its period. If `gen_run` drops in the same cycle that `fs_run` rises, the block goes to `SRG_IDLE`.
- R12: With F = 16·B−1 and W = 8·B−1 for a word of B bytes, frame sync is active for exactly half of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | Releases the bit-clock generator from reset |
| fs_run | input | 1 | Releases the frame-sync generator from reset |
| gen_cfg | input | 29 | Divide [7:0], width [15:8], period [27:16], frame-sync drive enable [28] |
| pol | input | 4 | Polarity: [0] receive clock, [1] transmit clock, [2] receive frame sync, [3] transmit frame sync |
| bclk_tx | output | 1 | Transmit bit clock |
| bclk_rx | output | 1 | Receive bit clock |
| fs_tx | output | 1 | Transmit frame sync |
| fs_rx | output | 1 | Receive frame sync |

## Verification
Two events can fall in the same cycle. The frame counter can reach its terminal count on the same edge where `fs_run` is removed. Separately, a rise of `fs_run` can meet a fall of `gen_run`. The bench provokes the first case by dropping `fs_run` exactly at the last divide count of the last bit of a frame. It then checks that frame sync goes inactive while the bit clock keeps its phase, cycle by cycle. For the second case the bench changes both run inputs at once and checks that the outputs go to their idle levels. The rest of the bench sweeps the divide, period, width and polarity settings, and compares every output on every cycle with values it computes from the cycle index.

// File: rtl/srg_pkg.sv
package srg_pkg;
    typedef enum logic [1:0] {
        SRG_IDLE     = 2'd0,
        SRG_CLK_ONLY = 2'd1,
        SRG_FRAMING  = 2'd2
    } srg_state_e;

    localparam int DIV_LSB   = 0;
    localparam int WID_LSB   = 8;
    localparam int PER_LSB   = 16;
    localparam int FSSEL_BIT = 28;
    localparam int CFG_W     = FSSEL_BIT + 1;
endpackage

// File: rtl/srg_bitclk_div.sv
module srg_bitclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             raw,
    output logic [DIV_W-1:0] cnt_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] dmax;
    logic [DIV_W-1:0] half;

    // A divide field of zero is stretched to one so the clock can toggle.
    assign dmax = (div == '0) ? DIV_W'(1) : div;
    assign half = dmax >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt >= dmax) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    assign tick  = en && (cnt >= dmax);
    assign raw   = en && (cnt > half);
    assign cnt_o = cnt;
endmodule

// File: rtl/srg_frame_ctr.sv
module srg_frame_ctr #(
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             drive_en,
    input  logic [PER_W-1:0] per,
    input  logic [WID_W-1:0] wid,
    output logic             fs_act,
    output logic [PER_W-1:0] fcnt_o
);
    localparam int CW = (PER_W > WID_W) ? PER_W : WID_W;

    logic [PER_W-1:0] fcnt;
    logic [CW-1:0]    per_x;
    logic [CW-1:0]    wid_x;
    logic [CW-1:0]    fcnt_x;
    logic             in_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (!run) begin
            fcnt <= '0;
        end else if (step) begin
            if (fcnt >= per) begin
                fcnt <= '0;
            end else begin
                fcnt <= fcnt + PER_W'(1);
            end
        end
    end

    assign per_x  = CW'(per);
    assign wid_x  = CW'(wid);
    assign fcnt_x = CW'(fcnt);

    // A width not shorter than the period leaves only the last bit inactive.
    assign in_pulse = (wid_x < per_x) ? (fcnt_x <= wid_x) : (fcnt_x != per_x);
    assign fs_act   = run && drive_en && in_pulse;
    assign fcnt_o   = fcnt;
endmodule

// File: rtl/srg_pol_out.sv
module srg_pol_out #(
    parameter int LANES = 2
) (
    input  logic             bclk_raw,
    input  logic             fs_act,
    input  logic [LANES-1:0] clk_pol,
    input  logic [LANES-1:0] fs_pol,
    output logic [LANES-1:0] bclk,
    output logic [LANES-1:0] fs
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bclk[i] = clk_pol[i] ? bclk_raw : ~bclk_raw;
        assign fs[i]   = fs_act ^ fs_pol[i];
    end
endmodule

// File: rtl/audio_srg.sv
module audio_srg
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int WID_W = 8,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_run,
    input  logic             fs_run,
    input  logic [CFG_W-1:0] gen_cfg,
    input  logic [3:0]       pol,
    output logic             bclk_tx,
    output logic             bclk_rx,
    output logic             fs_tx,
    output logic             fs_rx
);
    localparam int LANES = 2;

    srg_state_e       state;
    srg_state_e       nxt;
    logic             div_en;
    logic             frame_run;
    logic             bit_tick;
    logic             bclk_raw;
    logic             fs_act;
    logic [DIV_W-1:0] div_cnt;
    logic [PER_W-1:0] frm_cnt;
    logic [LANES-1:0] bclk_v;
    logic [LANES-1:0] fs_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SRG_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SRG_IDLE: begin
                if (gen_run) nxt = SRG_CLK_ONLY;
            end
            SRG_CLK_ONLY: begin
                if (!gen_run)                nxt = SRG_IDLE;
                else if (fs_run && bit_tick) nxt = SRG_FRAMING;
            end
            SRG_FRAMING: begin
                if (!gen_run)    nxt = SRG_IDLE;
                else if (!fs_run) nxt = SRG_CLK_ONLY;
            end
            default: nxt = SRG_IDLE;
        endcase
    end

    always_comb begin
        div_en    = (state != SRG_IDLE);
        frame_run = (state == SRG_FRAMING);
    end

    srg_bitclk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .div   (gen_cfg[DIV_LSB +: DIV_W]),
        .tick  (bit_tick),
        .raw   (bclk_raw),
        .cnt_o (div_cnt)
    );

    srg_frame_ctr #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (frame_run),
        .step     (bit_tick),
        .drive_en (gen_cfg[FSSEL_BIT]),
        .per      (gen_cfg[PER_LSB +: PER_W]),
        .wid      (gen_cfg[WID_LSB +: WID_W]),
        .fs_act   (fs_act),
        .fcnt_o   (frm_cnt)
    );

    // Lane 0 is receive, lane 1 is transmit.
    srg_pol_out #(.LANES(LANES)) u_pol (
        .bclk_raw (bclk_raw),
        .fs_act   (fs_act),
        .clk_pol  (pol[1:0]),
        .fs_pol   (pol[3:2]),
        .bclk     (bclk_v),
        .fs       (fs_v)
    );

    assign bclk_rx = bclk_v[0];
    assign bclk_tx = bclk_v[1];
    assign fs_rx   = fs_v[0];
    assign fs_tx   = fs_v[1];
endmodule

// File: rtl/audio_srg_chk.sv
module audio_srg_chk
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_run,
    input logic             fs_run,
    input logic [CFG_W-1:0] gen_cfg,
    input logic [3:0]       pol,
    input logic             bclk_tx,
    input logic             bclk_rx,
    input logic             fs_tx,
    input logic             fs_rx,
    input logic             tick,
    input logic [DIV_W-1:0] div_cnt,
    input logic [PER_W-1:0] frm_cnt
);
    logic [DIV_W-1:0] dmax;
    assign dmax = (gen_cfg[DIV_LSB +: DIV_W] == '0) ? DIV_W'(1) : gen_cfg[DIV_LSB +: DIV_W];

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen_run) |-> (bclk_tx == !pol[1]) && (fs_tx == pol[3]) && (fs_rx == pol[2])); // R4

    AST_FS_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fs_run) |-> (fs_tx == pol[3]) && (fs_rx == pol[2])); // R11

    AST_LANES_SHARE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_tx ^ pol[1]) == (bclk_rx ^ pol[0])); // R3

    AST_FS_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gen_run) && $past(fs_run) && $stable(gen_cfg) && $stable(pol)
         && (fs_tx != $past(fs_tx))) |-> $past(tick)); // R5

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(gen_cfg) |-> (div_cnt <= dmax)); // R2

    AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(gen_cfg) |-> (frm_cnt <= gen_cfg[PER_LSB +: PER_W])); // R6
endmodule

bind audio_srg audio_srg_chk #(.DIV_W(DIV_W), .PER_W(PER_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen_run (gen_run),
    .fs_run  (fs_run),
    .gen_cfg (gen_cfg),
    .pol     (pol),
    .bclk_tx (bclk_tx),
    .bclk_rx (bclk_rx),
    .fs_tx   (fs_tx),
    .fs_rx   (fs_rx),
    .tick    (bit_tick),
    .div_cnt (div_cnt),
    .frm_cnt (frm_cnt)
);

// File: tb/audio_srg_test.sv
module audio_srg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_run = 1'b0;
    logic        fs_run = 1'b0;
    logic [28:0] gen_cfg = '0;
    logic [3:0]  pol = '0;
    logic        bclk_tx, bclk_rx, fs_tx, fs_rx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_srg uut (
        .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_run(fs_run),
        .gen_cfg(gen_cfg), .pol(pol),
        .bclk_tx(bclk_tx), .bclk_rx(bclk_rx), .fs_tx(fs_tx), .fs_rx(fs_rx)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Idle levels: bit clock low internally, frame sync inactive (R1, R4).
    task automatic chk_idle(input string tag);
        chk({tag, " bclk_tx"}, bclk_tx, ~pol[1]);
        chk({tag, " bclk_rx"}, bclk_rx, ~pol[0]);
        chk({tag, " fs_tx"}, fs_tx, pol[3]);
        chk({tag, " fs_rx"}, fs_rx, pol[2]);
    endtask

    task automatic chk_lanes(input logic raw, input logic fsa);
        chk("R2 R3 bclk_tx", bclk_tx, pol[1] ? raw : ~raw);
        chk("R2 R3 bclk_rx", bclk_rx, pol[0] ? raw : ~raw);
        chk("R5 R6 R7 R8 R9 R10 fs_tx", fs_tx, fsa ^ pol[3]);
        chk("R5 R6 R7 R8 R9 R10 fs_rx", fs_rx, fsa ^ pol[2]);
    endtask

    // Starts both generators together and checks every cycle against
    // a model built from the cycle index; returns active count of frame 0.
    task automatic run_cfg(input int dv, input int per, input int wid,
                           input logic sel, input logic [3:0] pl,
                           input int nframes, output int act0);
        int d, p, ncyc;
        d = (dv == 0) ? 1 : dv;
        p = d + 1;
        ncyc = p + 1 + p * (per + 1) * nframes;
        act0 = 0;
        @(negedge clk);
        gen_cfg = {sel, 12'(per), 8'(wid), 8'(dv)};
        pol = pl;
        gen_run = 1'b1;
        fs_run = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            int cnt, fc, j;
            logic framing, raw, fsa;
            @(posedge clk);
            #1;
            if (k <= p) begin
                cnt = (k - 1) % p;
                framing = 1'b0;
                fc = 0;
            end else begin
                j = k - p - 1;
                cnt = j % p;
                fc = (j / p) % (per + 1);
                framing = 1'b1;
            end
            raw = (cnt > (d >> 1));
            if (!framing || !sel) fsa = 1'b0;
            else if (wid < per) fsa = (fc <= wid);
            else fsa = (fc != per);
            if (framing && (k - p - 1) < p * (per + 1) && fsa) act0++;
            chk_lanes(raw, fsa);
        end
        @(negedge clk);
        gen_run = 1'b0;
        fs_run = 1'b0;
        @(posedge clk);
        #1;
        chk_idle("R4 stop");
    endtask

    initial begin
        int act;
        #3;
        // R1: reset levels with pol = 0
        chk_idle("R1 in reset");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_idle("R1 after reset");

        // Sweep: divide, period/width pairs (covers R7 and R8), polarities.
        for (int dv = 0; dv < 4; dv++) begin
            for (int c = 0; c < 5; c++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    int per, wid;
                    logic [3:0] pl;
                    case (c)
                        0: begin per = 3;  wid = 1; end
                        1: begin per = 4;  wid = 0; end
                        2: begin per = 5;  wid = 5; end
                        3: begin per = 2;  wid = 7; end
                        default: begin per = 15; wid = 7; end
                    endcase
                    case (pi)
                        0: pl = 4'b0000;
                        1: pl = 4'b1111;
                        2: pl = 4'b0101;
                        default: pl = 4'b1010;
                    endcase
                    run_cfg(dv, per, wid, 1'b1, pl, 2, act);
                end
            end
        end

        // R10: frame-sync drive disabled, clock still checked per cycle.
        run_cfg(2, 3, 1, 1'b0, 4'b1100, 2, act);
        chk_int("R10 active count", act, 0);

        // R12: symmetric frames for 1- and 2-byte words.
        run_cfg(1, 15, 7, 1'b1, 4'b0000, 1, act);
        chk_int("R12 one byte", act, 2 * 8);
        run_cfg(1, 31, 15, 1'b1, 4'b1000, 1, act);
        chk_int("R12 two bytes", act, 2 * 16);

        // R11: fs_run removed exactly at terminal count (div 1, per 3, wid 1).
        @(negedge clk);
        gen_cfg = {1'b1, 12'd3, 8'd1, 8'd1};
        pol = 4'b0000;
        gen_run = 1'b1;
        fs_run = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk("R11 last bit inactive", fs_tx, 1'b0);
        @(negedge clk);
        fs_run = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #1;
            chk("R11 fs off", fs_tx, 1'b0);
            chk("R11 fs_rx off", fs_rx, 1'b0);
            chk("R11 bclk keeps phase", bclk_tx, (i % 2) == 1 ? 1'b0 : 1'b1);
        end
        // R11: gen_run falls as fs_run rises: idle wins.
        @(negedge clk);
        fs_run = 1'b1;
        gen_run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            chk_idle("R11 idle priority");
        end
        @(negedge clk);
        fs_run = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule